// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide parallel flash bus. It takes one request at a time from on-chip logic: write one byte, wipe one sector, wipe the whole array, or fetch the two identification bytes. It turns each request into the unlock write cycles that the flash expects. Once the last write cycle has finished, it reads the target location repeatedly until the device shows that it has finished. A one-cycle completion pulse carries the result: clean, read-back mismatch, or timed out.

Bus cycles are built from clock counts. A write holds chip-enable low, drives the address and data, and pulses write-enable low. A read holds chip-enable and output-enable low for an access wait. All three counts are parameters. Two completion detectors are available, chosen per request. One compares bit 7 of the polled byte against the expected value. The other watches bit 6 for two reads in a row that agree. In both cases, a read that seems to show completion is trusted only after two further reads confirm it.

Top module: `flash_pe_seq`

## Requirements
- R1: A write cycle drives chip-enable low with write-enable high for T_SETUP cycles, then write-enable low for T_PULSE cycles, then one more cycle with chip-enable low. Address and data are driven and held constant throughout, and output-enable stays high.
- R2: A read cycle holds chip-enable and output-enable low for T_ACC cycles with the data bus not driven, and samples the data in the last of those cycles. Chip-enable returns high for at least one cycle between any two bus cycles.
- R3: Op code 0 (program) writes, in order: 555h/AAh, 2AAh/55h, 555h/A0h, then the request address/data.
- R4: Op code 1 (sector erase) writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then request-address/20h. Op code 2 (chip erase) writes the same sequence but ends with 555h/10h.
- R5: Status reads address the request location and start only after the final write cycle of the sequence has finished.
- R6: With poll_toggle_i=0, a read is a completion candidate when its bit 7 equals bit 7 of the request data (program) or equals 1 (erase).
- R7: With poll_toggle_i=1, a read is a completion candidate when its bit 6 equals bit 6 of the previous read of the same operation. The first read is never a candidate.
- R8: A candidate is followed by two confirming reads. If either of them is not a candidate, polling resumes. Completion is never reported while the device is still busy.
- R9: After a confirmed program, one more read of the address is made. fail_o is set if that byte differs from the request data.
- R10: Each operation type has its own timeout limit in cycles, counted from the start of polling. A status read that finishes at or after the limit ends the operation with timeout_o=1 and a done_o pulse.
- R11: Op code 3 (identify) writes 555h/AAh, 2AAh/55h, 555h/90h. It then reads address 0 into id_o[15:8] and address 1 into id_o[7:0], and finally writes 555h/F0h.
- R12: busy_o is high from the cycle after a request is accepted until the done_o cycle, in which it is low. Requests made while busy_o is high are ignored.
- R13: After reset, the bus is idle (chip-enable, output-enable and write-enable high, data not driven), and busy_o, done_o, fail_o and timeout_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_op_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 identify |
| req_addr_i | input | AW | Byte or sector address |
| req_data_i | input | 8 | Byte to program |
| poll_toggle_i | input | 1 | 0 bit-7 polling, 1 bit-6 toggle polling |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Read-back mismatch of last program |
| timeout_o | output | 1 | Last operation timed out |
| id_o | output | 16 | Identification bytes (first, second) |
| fl_addr_o | output | AW | Flash address |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_oe_o | output | 1 | Flash data output enable |
| fl_dq_i | input | 8 | Flash read data |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_oe_no | output | 1 | Output enable, active low |
| fl_we_no | output | 1 | Write enable, active low |

## Verification
The risky overlap is when the device finishes its internal operation during the same poll read the sequencer is judging. Here a single read can look finished while the device is still busy. The bench flash model provokes this by returning one finished-looking value on a chosen read during the busy period: bit 7 true and bit 6 held rather than flipped. The bench judges the case by requiring that done_o never pulses while the model is still busy. It also requires that the operation still ends cleanly, in both polling modes.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2, OP_ID = 2'd3} fop_e;

  localparam logic [11:0] ADR_A = 12'h555;
  localparam logic [11:0] ADR_B = 12'h2AA;
  localparam logic [7:0] D_UNL1 = 8'hAA;
  localparam logic [7:0] D_UNL2 = 8'h55;
  localparam logic [7:0] C_PROG = 8'hA0;
  localparam logic [7:0] C_ERS  = 8'h80;
  localparam logic [7:0] C_SECT = 8'h20;
  localparam logic [7:0] C_CHIP = 8'h10;
  localparam logic [7:0] C_ID   = 8'h90;
  localparam logic [7:0] C_EXIT = 8'hF0;

  typedef struct packed {
    logic [11:0] a;
    logic [7:0]  d;
    logic        use_addr;
    logic        use_data;
  } step_t;
endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle #(
  parameter int AW      = 19,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3,
  parameter int T_ACC   = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          ack_o,
  output logic [7:0]    rdata_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_oe_no,
  output logic          fl_we_no
);
  localparam int CMAX = (T_ACC > T_SETUP) ? ((T_ACC > T_PULSE) ? T_ACC : T_PULSE)
                                          : ((T_SETUP > T_PULSE) ? T_SETUP : T_PULSE);
  localparam int CW = $clog2(CMAX + 1);

  typedef enum logic [2:0] {B_IDLE, B_SETUP, B_PULSE, B_HOLD, B_READ, B_GAP} bst_e;

  bst_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= B_IDLE; cnt_q <= '0; addr_q <= '0; data_q <= '0; rdata_q <= '0;
    end else begin
      case (st_q)
        B_IDLE: if (start_i) begin
          addr_q <= addr_i; data_q <= wdata_i; cnt_q <= '0;
          st_q   <= wr_i ? B_SETUP : B_READ;
        end
        B_SETUP: if (cnt_q == CW'(T_SETUP - 1)) begin cnt_q <= '0; st_q <= B_PULSE; end
                 else cnt_q <= cnt_q + 1'b1;
        B_PULSE: if (cnt_q == CW'(T_PULSE - 1)) begin cnt_q <= '0; st_q <= B_HOLD; end
                 else cnt_q <= cnt_q + 1'b1;
        B_HOLD:  st_q <= B_GAP;
        B_READ:  if (cnt_q == CW'(T_ACC - 1)) begin rdata_q <= fl_dq_i; st_q <= B_GAP; end
                 else cnt_q <= cnt_q + 1'b1;
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign fl_addr_o  = addr_q;
  assign fl_dq_o    = data_q;
  assign fl_dq_oe_o = (st_q == B_SETUP) || (st_q == B_PULSE) || (st_q == B_HOLD);
  assign fl_we_no   = (st_q != B_PULSE);
  assign fl_oe_no   = (st_q != B_READ);
  assign fl_ce_no   = !(fl_dq_oe_o || (st_q == B_READ));
  assign ack_o      = (st_q == B_GAP);
  assign rdata_o    = rdata_q;

  assert_we_in_ce_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> (!fl_ce_no && fl_oe_no));
  assert_addr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_ce_no && $past(!fl_ce_no)) |-> ($stable(fl_addr_o) && $stable(fl_dq_o)));
  assert_read_nodrive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> !fl_dq_oe_o);
  assert_start_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (st_q == B_IDLE));
endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rd_ack_i,
  input  logic toggle_i,
  input  logic expect7_i,
  input  logic rd7_i,
  input  logic rd6_i,
  output logic hit_o
);
  logic prev6_q, have_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev6_q <= 1'b0; have_prev_q <= 1'b0;
    end else if (clr_i) begin
      have_prev_q <= 1'b0;
    end else if (rd_ack_i) begin
      prev6_q <= rd6_i; have_prev_q <= 1'b1;
    end
  end

  // candidate verdict for the read finishing this cycle
  assign hit_o = toggle_i ? (have_prev_q && (rd6_i == prev6_q)) : (rd7_i == expect7_i);
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_pe_pkg::*;
#(
  parameter int AW      = 19,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3,
  parameter int T_ACC   = 18,
  parameter int TO_PROG = 6000,
  parameter int TO_SECT = 6250000,
  parameter int TO_CHIP = 25000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [7:0]    req_data_i,
  input  logic          poll_toggle_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          timeout_o,
  output logic [15:0]   id_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_oe_no,
  output logic          fl_we_no
);
  localparam int TOMAX = (TO_CHIP > TO_SECT) ? ((TO_CHIP > TO_PROG) ? TO_CHIP : TO_PROG)
                                             : ((TO_SECT > TO_PROG) ? TO_SECT : TO_PROG);
  localparam int TW = $clog2(TOMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_POLL, S_CONF, S_VERIFY, S_IDRD, S_EXIT} st_e;

  st_e           st_q;
  fop_e          op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          tog_q, pend_q, conf_q, done_q, fail_q, to_q;
  logic [2:0]    step_q, last_step;
  logic [TW-1:0] tcnt_q, limit;
  logic [15:0]   id_q;

  logic          bus_start, bus_wr, bus_ack, hit, tmo, poll_ack, judge_clr;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  step_t         stp;

  function automatic step_t cmd_step(fop_e op, logic [2:0] k);
    step_t s;
    s = '{a: ADR_A, d: D_UNL1, use_addr: 1'b0, use_data: 1'b0};
    case (k)
      3'd0: ;
      3'd1: begin s.a = ADR_B; s.d = D_UNL2; end
      3'd2: s.d = (op == OP_PROG) ? C_PROG : ((op == OP_ID) ? C_ID : C_ERS);
      3'd3: if (op == OP_PROG) begin s.use_addr = 1'b1; s.use_data = 1'b1; end
      3'd4: begin s.a = ADR_B; s.d = D_UNL2; end
      default: begin s.d = (op == OP_SECT) ? C_SECT : C_CHIP; s.use_addr = (op == OP_SECT); end
    endcase
    return s;
  endfunction

  always_comb begin
    stp       = cmd_step(op_q, step_q);
    last_step = (op_q == OP_PROG) ? 3'd3 : ((op_q == OP_ID) ? 3'd2 : 3'd5);
    bus_wr    = (st_q == S_CMD) || (st_q == S_EXIT);
    bus_start = (st_q != S_IDLE) && !pend_q;
    case (st_q)
      S_CMD:   bus_addr = stp.use_addr ? addr_q : AW'(stp.a);
      S_EXIT:  bus_addr = AW'(ADR_A);
      S_IDRD:  bus_addr = AW'(step_q[0]);
      default: bus_addr = addr_q;
    endcase
    bus_wdata = (st_q == S_CMD) ? (stp.use_data ? data_q : stp.d) : C_EXIT;
    case (op_q)
      OP_PROG: limit = TW'(TO_PROG);
      OP_SECT: limit = TW'(TO_SECT);
      default: limit = TW'(TO_CHIP);
    endcase
  end

  assign tmo       = (tcnt_q >= limit);
  assign poll_ack  = bus_ack && ((st_q == S_POLL) || (st_q == S_CONF));
  assign judge_clr = bus_ack && (st_q == S_CMD) && (step_q == last_step);

  flash_bus_cycle #(.AW(AW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_ACC(T_ACC)) u_bus (
    .clk_i, .rst_ni, .start_i(bus_start), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .ack_o(bus_ack), .rdata_o(bus_rdata),
    .fl_addr_o, .fl_dq_o, .fl_dq_oe_o, .fl_dq_i, .fl_ce_no, .fl_oe_no, .fl_we_no
  );

  flash_poll_judge u_judge (
    .clk_i, .rst_ni, .clr_i(judge_clr), .rd_ack_i(poll_ack), .toggle_i(tog_q),
    .expect7_i((op_q == OP_PROG) ? data_q[7] : 1'b1),
    .rd7_i(bus_rdata[7]), .rd6_i(bus_rdata[6]), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; op_q <= OP_PROG; addr_q <= '0; data_q <= '0; tog_q <= 1'b0;
      pend_q <= 1'b0; conf_q <= 1'b0; done_q <= 1'b0; fail_q <= 1'b0; to_q <= 1'b0;
      step_q <= '0; tcnt_q <= '0; id_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (bus_start) pend_q <= 1'b1;
      if (bus_ack)   pend_q <= 1'b0;
      if (((st_q == S_POLL) || (st_q == S_CONF)) && !tmo) tcnt_q <= tcnt_q + 1'b1;
      case (st_q)
        S_IDLE: if (req_valid_i) begin
          op_q <= fop_e'(req_op_i); addr_q <= req_addr_i; data_q <= req_data_i;
          tog_q <= poll_toggle_i; step_q <= '0; fail_q <= 1'b0; to_q <= 1'b0;
          st_q <= S_CMD;
        end
        S_CMD: if (bus_ack) begin
          if (step_q == last_step) begin
            step_q <= '0; tcnt_q <= '0; conf_q <= 1'b0;
            st_q <= (op_q == OP_ID) ? S_IDRD : S_POLL;
          end else step_q <= step_q + 1'b1;
        end
        S_POLL: if (bus_ack) begin
          if (tmo) begin to_q <= 1'b1; done_q <= 1'b1; st_q <= S_IDLE; end
          else if (hit) begin conf_q <= 1'b0; st_q <= S_CONF; end
        end
        S_CONF: if (bus_ack) begin
          if (tmo) begin to_q <= 1'b1; done_q <= 1'b1; st_q <= S_IDLE; end
          else if (!hit) st_q <= S_POLL;
          else if (!conf_q) conf_q <= 1'b1;
          else if (op_q == OP_PROG) st_q <= S_VERIFY;
          else begin done_q <= 1'b1; st_q <= S_IDLE; end
        end
        S_VERIFY: if (bus_ack) begin
          fail_q <= (bus_rdata != data_q); done_q <= 1'b1; st_q <= S_IDLE;
        end
        S_IDRD: if (bus_ack) begin
          if (!step_q[0]) begin id_q[15:8] <= bus_rdata; step_q <= 3'd1; end
          else begin id_q[7:0] <= bus_rdata; st_q <= S_EXIT; end
        end
        S_EXIT: if (bus_ack) begin done_q <= 1'b1; st_q <= S_IDLE; end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = done_q;
  assign fail_o    = fail_q;
  assign timeout_o = to_q;
  assign id_o      = id_q;

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_poll_after_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> ((st_q != S_CMD) && (st_q != S_EXIT)));
  assert_erase_conf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !timeout_o && ((op_q == OP_SECT) || (op_q == OP_CHIP))) |-> ($past(st_q) == S_CONF));
  assert_fail_to_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fail_o && timeout_o));
  assert_to_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);
endmodule

// File: tb/sim_flash_pe_seq.sv
module sim_flash_pe_seq;
  localparam int AW = 19, TS = 2, TP = 3, TA = 6, TOP = 600, TOS = 900, TOC = 1200;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, poll_tog = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic busy, done, fail, tmo;
  logic [15:0] id;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_o, fl_dq_i;
  logic fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  flash_pe_seq #(.AW(AW), .T_SETUP(TS), .T_PULSE(TP), .T_ACC(TA),
                 .TO_PROG(TOP), .TO_SECT(TOS), .TO_CHIP(TOC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data), .poll_toggle_i(poll_tog),
    .busy_o(busy), .done_o(done), .fail_o(fail), .timeout_o(tmo), .id_o(id),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_no(fl_ce_n), .fl_oe_no(fl_oe_n), .fl_we_no(fl_we_n));

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural flash device
  logic [7:0] mem [int];
  logic [7:0] rd_val = 8'hFF;
  assign fl_dq_i = rd_val;
  int busy_left = 0, busy_kind = 0, busy_a = 0, busy_len = 100, glitch_idx = 0, rd_in_busy = 0;
  logic [7:0] busy_d = '0, store_d = '0, dev_id = 8'h37;
  logic tog = 1'b0;
  bit id_mode = 0, corrupt = 0, in_op = 0;
  int wa_q[$], wd_q[$], ca_q[$], cd_q[$], ea_q[$], ed_q[$];
  int exp_writes = 0, ce_cnt = 0, we_cnt = 0, oe_cnt = 0, a_fall = 0;
  logic p_we = 1'b1, p_oe = 1'b1;

  task automatic flash_write(int a, int d);
    int am, n;
    bit ok;
    wa_q.push_back(a); wd_q.push_back(d);
    if (busy_left > 0) return;
    if (id_mode && d == 'hF0) begin id_mode = 0; ca_q.delete(); cd_q.delete(); return; end
    am = a & 'h7FF;
    ca_q.push_back(am); cd_q.push_back(d); n = ca_q.size(); ok = 0;
    case (n)
      1, 4: ok = (am == 'h555 && d == 'hAA);
      2, 5: ok = (am == 'h2AA && d == 'h55);
      3: ok = (am == 'h555 && (d == 'hA0 || d == 'h80 || d == 'h90));
      default: ok = 0;
    endcase
    if (n == 3 && ok && d == 'h90) begin id_mode = 1; ok = 0; end
    if (n == 4 && cd_q[2] == 'hA0) begin
      busy_kind = 1; busy_a = a; busy_d = 8'(d); store_d = corrupt ? 8'(d ^ 1) : 8'(d);
      busy_left = busy_len; rd_in_busy = 0; ok = 0;
    end
    if (n == 6) begin
      if (d == 'h20) begin busy_kind = 2; busy_a = a; busy_left = busy_len; rd_in_busy = 0; end
      else if (d == 'h10 && am == 'h555) begin busy_kind = 3; busy_left = busy_len; rd_in_busy = 0; end
      ok = 0;
    end
    if (!ok) begin ca_q.delete(); cd_q.delete(); end
  endtask

  task automatic flash_read_start(int a);
    logic [7:0] v;
    if (busy_left > 0) begin
      rd_in_busy++;
      if (rd_in_busy == glitch_idx) begin
        v = (busy_kind == 1) ? busy_d : 8'hFF; v[6] = tog;   // finished-looking race read
      end else begin
        tog = ~tog;
        v = {(busy_kind == 1) ? ~busy_d[7] : 1'b0, tog, 6'b0};
      end
    end else if (id_mode) v = a[0] ? dev_id : 8'hBF;
    else v = mem.exists(a) ? mem[a] : 8'hFF;
    rd_val = v;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(fl_we_n || (!fl_ce_n && fl_oe_n), "R1", "we low outside ce", fl_we_n, 0);
      chk(busy == (in_op && !done), "R12", "busy", busy, in_op && !done);
      if (p_we && !fl_we_n) begin
        chk(ce_cnt == TS, "R1", "setup cycles", ce_cnt, TS);
        a_fall = int'(fl_addr); we_cnt = 0;
      end
      if (!fl_we_n) we_cnt++;
      if (!p_we && fl_we_n) begin
        chk(we_cnt == TP, "R1", "pulse cycles", we_cnt, TP);
        chk(int'(fl_addr) == a_fall && fl_dq_oe && !fl_ce_n, "R1", "addr/data at rise", fl_addr, a_fall);
        flash_write(int'(fl_addr), int'(fl_dq_o));
      end
      if (fl_ce_n) ce_cnt = 0; else if (fl_we_n && fl_oe_n) ce_cnt++;
      if (p_oe && !fl_oe_n) begin
        chk(wa_q.size() == exp_writes, "R5", "read before sequence end", wa_q.size(), exp_writes);
        chk(!fl_dq_oe && !fl_ce_n, "R2", "read bus state", fl_dq_oe, 0);
        flash_read_start(int'(fl_addr));
        oe_cnt = 0;
      end
      if (!fl_oe_n) oe_cnt++;
      if (!p_oe && fl_oe_n) chk(oe_cnt == TA, "R2", "access cycles", oe_cnt, TA);
      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) begin
          if (busy_kind == 1) mem[busy_a] = store_d;
          else if (busy_kind == 2) for (int i = 0; i < 128; i++) mem.delete((busy_a & ~127) + i);
          else mem.delete();
        end
      end
      p_we = fl_we_n; p_oe = fl_oe_n;
    end
  end

  task automatic build_exp(int op, int a, int d);
    ea_q.delete(); ed_q.delete();
    ea_q.push_back('h555); ed_q.push_back('hAA);
    ea_q.push_back('h2AA); ed_q.push_back('h55);
    ea_q.push_back('h555);
    case (op)
      0: begin ed_q.push_back('hA0); ea_q.push_back(a); ed_q.push_back(d); end
      3: begin ed_q.push_back('h90); ea_q.push_back('h555); ed_q.push_back('hF0); end
      default: begin
        ed_q.push_back('h80);
        ea_q.push_back('h555); ed_q.push_back('hAA);
        ea_q.push_back('h2AA); ed_q.push_back('h55);
        ea_q.push_back(op == 1 ? a : 'h555); ed_q.push_back(op == 1 ? 'h20 : 'h10);
      end
    endcase
  endtask

  task automatic run_op(int op, int a, int d, bit tmode, int blen, int gidx, bit corr,
                        bit exp_fail, bit exp_to, int lo, int hi, string tag);
    int cyc;
    busy_len = blen; glitch_idx = gidx; corrupt = corr;
    wa_q.delete(); wd_q.delete();
    exp_writes = (op == 0) ? 4 : ((op == 3) ? 3 : 6);
    build_exp(op, a, d);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = AW'(a); req_data = 8'(d); poll_tog = tmode;
    @(posedge clk); in_op = 1;
    @(negedge clk); req_op = 2'd2; req_addr = AW'('h7777);   // ignored while busy (R12)
    @(negedge clk); req_valid = 1'b0;
    cyc = 2;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    in_op = 0;
    chk(done, tag, "done pulse seen", done, 1);
    chk(fail == exp_fail, "R9", {tag, " fail_o"}, fail, exp_fail);
    chk(tmo == exp_to, "R10", {tag, " timeout_o"}, tmo, exp_to);
    if (!exp_to) chk(busy_left == 0, "R8", {tag, " done while device busy"}, busy_left, 0);
    if (hi > 0) chk(cyc >= lo && cyc <= hi, "R10", {tag, " timeout cycle"}, cyc, lo);
    chk(wa_q.size() == ea_q.size(), tag, "write count", wa_q.size(), ea_q.size());
    foreach (ea_q[i]) if (i < wa_q.size()) begin
      chk(wa_q[i] == ea_q[i], tag, $sformatf("write %0d addr", i), wa_q[i], ea_q[i]);
      chk(wd_q[i] == ed_q[i], tag, $sformatf("write %0d data", i), wd_q[i], ed_q[i]);
    end
    if (exp_to) begin busy_left = 0; ca_q.delete(); cd_q.delete(); end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R13", "bus idle in reset", {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail && !tmo, "R13", "status after reset", {busy, done, fail, tmo}, 0);
    chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R13", "bus after reset", {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);

    run_op(0, 'h01234, 'h5A, 0, 200, 0, 0, 0, 0, 0, 0, "R3 R6 program bit7");
    run_op(0, 'h04321, 'hC3, 1, 250, 0, 0, 0, 0, 0, 0, "R3 R7 program toggle");
    run_op(0, 'h00F00, 'h3C, 0, 300, 2, 0, 0, 0, 0, 0, "R8 race bit7");
    run_op(0, 'h00F01, 'hA5, 1, 300, 3, 0, 0, 0, 0, 0, "R8 race toggle");
    run_op(0, 'h00100, 'h81, 0, 150, 0, 1, 1, 0, 0, 0, "R9 readback mismatch");
    run_op(1, 'h02A80, 'h00, 0, 300, 0, 0, 0, 0, 0, 0, "R4 R6 sector erase");
    run_op(2, 'h00000, 'h00, 1, 350, 4, 0, 0, 0, 0, 0, "R4 R7 chip erase");
    run_op(3, 'h00000, 'h00, 0, 0, 0, 0, 0, 0, 0, 0, "R11 identify");
    chk(id == 16'hBF37, "R11", "id bytes", id, 16'hBF37);
    chk(!id_mode, "R11", "identify mode left", id_mode, 0);
    run_op(0, 'h00200, 'h11, 0, 50000, 0, 0, 0, 1, TOP, TOP + 80, "R10 program timeout");
    run_op(1, 'h03000, 'h00, 1, 50000, 0, 0, 0, 1, TOS, TOS + 100, "R10 sector timeout");
    run_op(0, 'h00300, 'h7E, 0, 100, 0, 0, 0, 0, 0, 0, "R12 after timeout");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule